// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

This block gathers 32 second-level interrupt inputs, arranged as four byte-wide groups, and folds them onto 12 first-level request lines that go to the processor's interrupt logic. Each input is first synchronised to the block clock. It is then corrected for its own idle level, so a source is active whenever its input differs from the level it rests at. Masks at two levels decide what is forwarded. Every source has a mask bit in one of four second-level mask bytes. Every first-level line has a mask bit in one of two first-level mask bytes. A mask bit of 1 blocks and 0 passes.

The source-to-line map is fixed and irregular. Most lines collect a few adjacent bits of one status byte. The top four sources are spare and never reach any line. Software uses a byte-wide register bus with an address, a write strobe, a read strobe and data. Through it, software reads the raw input levels, reads and writes the masks, and reads one vector register per line. The vector gives the lowest-numbered pending source under that line, so a handler does not have to scan the status bytes.

Top module: `irq_agg_ctrl`

## Requirements
- R1: While reset is held, and after reset until software writes them, all six mask bytes read 0xFF and every first-level output is 0, whatever the inputs do.
- R2: Source n is active when its synchronised input differs from its idle level. Source n is bit n%8 of group n/8, and the idle bytes of groups 0, 1, 2 and 3 are 0xF7 for group 3, 0xFC for group 2, 0xBE for group 1 and 0x00 for group 0.
- R3: The map from sources to first-level lines is: 0–7 to line 7, 8 to line 4, 9–13 to line 6, 14 to line 8, 15 to line 9, 16–17 to line 11, 18–21 to line 5, 22 to line 0, 23 to line 1, 24 to line 3, 25–26 to line 10, and 27 to line 2.
- R4: A line's output is 1 only when at least one of its sources is active with its second-level mask bit clear, and the line's own first-level mask bit is clear. Second-level mask bit n%8 of the byte at offset 4+n/8 belongs to source n. First-level mask bit l%8 of the byte at offset 8+l/8 belongs to line l.
- R5: Sources 28 to 31 never cause any first-level output.
- R6: The vector byte for line l sits at offset 0x10+l. Bit 7 is set when some source of that line is active with its second-level mask clear, and bits 4:0 then hold the lowest such source number (group×8 + bit). The whole byte reads 0 when no source of the line is pending. The first-level mask does not affect the vector.
- R7: Offsets 0 to 3 read back the synchronised raw input levels of groups 0 to 3, with no polarity correction. A mask byte reads back the last value written to it.
- R8: Writes to the status offsets (0–3) and to the vector offsets (0x10–0x1B) change nothing. Reads of every offset outside 0–9 and 0x10–0x1B return 0.
- R9: A change on an input reaches the first-level output on the third rising clock edge after it is applied. A mask write changes the output on the edge after the write edge. Read data appears on the edge that samples the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_raw | input | 32 | Asynchronous second-level inputs, source n on bit n |
| bus_addr | input | 5 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_out | output | 12 | First-level request lines, line l on bit l |

## Verification
On every cycle the assertions check four things. An asserted output always had its first-level mask bit clear on the edge before. The outputs are quiet on the first cycle after reset. The mask bytes hold unless a write strobe is present. Any valid vector names a pending member source, and no pending member with a lower number exists. The bench scenarios are the only check of the map itself, the idle-level patterns, the exact latency through the synchroniser, the spare sources, and the register map. That includes writes that must be ignored and offsets that must read zero.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

   localparam int SRC_TOTAL  = 32;
   localparam int LINE_TOTAL = 12;
   localparam int NO_LINE    = 15;

   // first-level line fed by a second-level source; NO_LINE for spares
   function automatic int src_line(int n);
      if (n < 8)   return 7;
      if (n == 8)  return 4;
      if (n <= 13) return 6;
      if (n == 14) return 8;
      if (n == 15) return 9;
      if (n <= 17) return 11;
      if (n <= 21) return 5;
      if (n == 22) return 0;
      if (n == 23) return 1;
      if (n == 24) return 3;
      if (n <= 26) return 10;
      if (n == 27) return 2;
      return NO_LINE;
   endfunction

   function automatic logic [SRC_TOTAL-1:0] line_members(int l);
      logic [SRC_TOTAL-1:0] m;
      m = '0;
      for (int n = 0; n < SRC_TOTAL; n++)
         if (src_line(n) == l) m[n] = 1'b1;
      return m;
   endfunction

   function automatic logic [7:0] idle_byte(int g);
      case (g)
         1:       return 8'hBE;
         2:       return 8'hFC;
         3:       return 8'hF7;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [SRC_TOTAL-1:0] idle_all();
      logic [SRC_TOTAL-1:0] v;
      for (int g = 0; g < SRC_TOTAL/8; g++) v[g*8 +: 8] = idle_byte(g);
      return v;
   endfunction

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_MASK2,
      SEL_MASK1,
      SEL_VEC
   } reg_sel_e;

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("irqagg_sync needs at least two stages");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= '0;
      else     chain[0] <= d;
   end

   genvar s;
   generate
      for (s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irqagg_line.sv
module irqagg_line
   import irqagg_pkg::*;
#(
   parameter int LINE_ID = 0,
   parameter int NUM_W   = 5
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [SRC_TOTAL-1:0] pend,
   output logic                 hit,
   output logic [7:0]           vec
);
   localparam logic [SRC_TOTAL-1:0] MEMBERS = line_members(LINE_ID);

   generate
      if (NUM_W + 1 > 8 || (1 << NUM_W) < SRC_TOTAL) begin : g_bad
         $error("irqagg_line source number does not fit the vector byte");
      end
   endgenerate

   logic [SRC_TOTAL-1:0] mine;
   logic [NUM_W-1:0]     sel;

   assign mine = pend & MEMBERS;
   assign hit  = |mine;

   always_comb begin
      sel = '0;
      for (int i = SRC_TOTAL - 1; i >= 0; i--)
         if (mine[i]) sel = NUM_W'(i);
   end

   always_comb begin
      vec = '0;
      if (hit) begin
         vec[7]         = 1'b1;
         vec[NUM_W-1:0] = sel;
      end
   end

   // R6: a valid vector names a pending member and nothing lower is pending
   assert_vec_lowest_R6: assert property (@(posedge clk) disable iff (rst)
      vec[7] |-> (MEMBERS[vec[NUM_W-1:0]] && pend[vec[NUM_W-1:0]] &&
                  ((pend & MEMBERS & ((32'd1 << vec[NUM_W-1:0]) - 32'd1)) == '0)));

   // R5: spare sources are never members of a line
   assert_vec_no_spare_R5: assert property (@(posedge clk) disable iff (rst)
      vec[7] |-> (src_line(int'(vec[NUM_W-1:0])) == LINE_ID));
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
   import irqagg_pkg::*;
#(
   parameter int GRP_W       = 8,
   parameter int N_GRP       = 4,
   parameter int N_LINE      = 12,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [31:0]       irq_raw,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic [11:0]       irq_out
);
   localparam int N_SRC    = N_GRP * GRP_W;
   localparam int N_M1     = (N_LINE + GRP_W - 1) / GRP_W;
   localparam int OFF_M2   = N_GRP;
   localparam int OFF_M1   = OFF_M2 + N_GRP;
   localparam int OFF_VEC  = 16;
   localparam logic [N_SRC-1:0] IDLE = idle_all();

   generate
      if (GRP_W != 8 || N_SRC != SRC_TOTAL || N_LINE != LINE_TOTAL) begin : g_bad_shape
         $error("irq_agg_ctrl supports only the fixed 32-source, 12-line map");
      end
      if ((1 << ADDR_W) < OFF_VEC + N_LINE) begin : g_bad_addr
         $error("irq_agg_ctrl address too narrow for the register map");
      end
   endgenerate

   // input synchronisation and polarity correction
   logic [N_SRC-1:0] raw_s, active, pend;
   irqagg_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(irq_raw), .q(raw_s)
   );
   assign active = raw_s ^ IDLE;

   // mask storage
   logic [GRP_W-1:0] m2_q [N_GRP];
   logic [GRP_W-1:0] m1_q [N_M1];
   logic [N_SRC-1:0] m2_flat;
   logic [N_M1*GRP_W-1:0] m1_flat;

   reg_sel_e             sel;
   int unsigned          idx;

   always_comb begin
      sel = SEL_NONE;
      idx = 0;
      if (int'(bus_addr) < N_GRP) begin
         sel = SEL_STAT;  idx = int'(bus_addr);
      end else if (int'(bus_addr) < OFF_M1) begin
         sel = SEL_MASK2; idx = int'(bus_addr) - OFF_M2;
      end else if (int'(bus_addr) < OFF_M1 + N_M1) begin
         sel = SEL_MASK1; idx = int'(bus_addr) - OFF_M1;
      end else if (int'(bus_addr) >= OFF_VEC && int'(bus_addr) < OFF_VEC + N_LINE) begin
         sel = SEL_VEC;   idx = int'(bus_addr) - OFF_VEC;
      end
   end

   genvar g;
   generate
      for (g = 0; g < N_GRP; g++) begin : g_m2
         always_ff @(posedge clk) begin
            if (rst)                                       m2_q[g] <= '1;
            else if (bus_wr && sel == SEL_MASK2 && idx == g) m2_q[g] <= bus_wdata;
         end
         assign m2_flat[g*GRP_W +: GRP_W] = m2_q[g];
      end
      for (g = 0; g < N_M1; g++) begin : g_m1
         always_ff @(posedge clk) begin
            if (rst)                                       m1_q[g] <= '1;
            else if (bus_wr && sel == SEL_MASK1 && idx == g) m1_q[g] <= bus_wdata;
         end
         assign m1_flat[g*GRP_W +: GRP_W] = m1_q[g];
      end
   endgenerate

   assign pend = active & ~m2_flat;

   // per-line aggregation and vector encoding
   logic [N_LINE-1:0] hit;
   logic [7:0]        vec [N_LINE];

   genvar l;
   generate
      for (l = 0; l < N_LINE; l++) begin : g_line
         irqagg_line #(.LINE_ID(l), .NUM_W($clog2(N_SRC))) u_line (
            .clk(clk), .rst(rst), .pend(pend), .hit(hit[l]), .vec(vec[l])
         );
      end
   endgenerate

   logic [N_LINE-1:0] irq_q;
   always_ff @(posedge clk) begin
      if (rst) irq_q <= '0;
      else     irq_q <= hit & ~m1_flat[N_LINE-1:0];
   end
   assign irq_out = irq_q;

   // read path
   logic [7:0] rd_mux, rdata_q;
   always_comb begin
      case (sel)
         SEL_STAT:  rd_mux = raw_s[idx*GRP_W +: GRP_W];
         SEL_MASK2: rd_mux = m2_q[idx];
         SEL_MASK1: rd_mux = m1_q[idx];
         SEL_VEC:   rd_mux = vec[idx];
         default:   rd_mux = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst)         rdata_q <= '0;
      else if (bus_rd) rdata_q <= rd_mux;
   end
   assign bus_rdata = rdata_q;

   // R1: outputs quiet on the first cycle after reset
   assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (irq_out == '0));

   // R4: an asserted line had its first-level mask bit clear one edge earlier
   generate
      for (l = 0; l < N_LINE; l++) begin : g_chk
         assert_l1_gate_R4: assert property (@(posedge clk) disable iff (rst)
            irq_out[l] |-> !$past(m1_flat[l]));
      end
   endgenerate

   // R7: mask bytes hold without a write strobe
   assert_mask_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !bus_wr |=> ($stable(m2_flat) && $stable(m1_flat)));
endmodule

// File: tb/sim_irq_agg_ctrl.sv
module sim_irq_agg_ctrl;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] irq_raw = 32'hF7FC_BE00;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [11:0] irq_out;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   localparam logic [31:0] IDLE_RAW = 32'hF7FC_BE00;
   localparam logic [31:0] ALL_ACT  = 32'h0803_41FF;

   // {raw inputs, expected first-level outputs} with all masks open
   localparam logic [43:0] TBL [12] = '{
      {32'hF7FC_BE00, 12'h000},
      {32'hF7FC_BE01, 12'h080},
      {32'hF7FC_BF00, 12'h010},
      {32'hF7FC_FE00, 12'h100},
      {32'hF7BC_BE00, 12'h001},
      {32'hFFFC_BE00, 12'h004},
      {32'h07FC_BE00, 12'h000},
      {32'h0803_41FF, 12'hFFF},
      {32'hF7FD_BE00, 12'h800},
      {32'hF5FC_BE00, 12'h400},
      {32'hF778_BE00, 12'h022},
      {32'hF6FC_3C00, 12'h248}
   };

   // lowest source per line with every source active
   localparam logic [4:0] LOWEST [12] = '{5'd22, 5'd23, 5'd27, 5'd24, 5'd8, 5'd18,
                                          5'd9, 5'd0, 5'd14, 5'd15, 5'd25, 5'd16};

   irq_agg_ctrl u0 (
      .clk(clk), .rst(rst), .irq_raw(irq_raw), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] d;
      // R1: all sources active during and after reset, masks closed
      irq_raw = ALL_ACT;
      settle(5);
      chk("R1 outputs in reset", 32'(irq_out), 32'h0);
      rst = 1'b0;
      settle(4);
      chk("R1 outputs after reset", 32'(irq_out), 32'h0);
      for (int a = 4; a < 10; a++) begin
         rd(5'(a), d);
         chk("R1 mask reset value", 32'(d), 32'hFF);
      end

      // R7: status bytes read raw levels
      for (int g = 0; g < 4; g++) begin
         rd(5'(g), d);
         chk("R7 status readback", 32'(d), 32'(ALL_ACT[g*8 +: 8]));
      end

      // open all masks, check mask readback
      for (int a = 4; a < 10; a++) wr(5'(a), 8'h00);
      wr(5'd5, 8'h5A);
      rd(5'd5, d);
      chk("R7 mask readback", 32'(d), 32'h5A);
      wr(5'd5, 8'h00);

      // R2 R3 R5: table walk
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         irq_raw = TBL[i][43:12];
         settle(4);
         chk($sformatf("R2/R3/R5 table row %0d", i), 32'(irq_out), 32'(TBL[i][11:0]));
      end

      // R6: vectors with every source active
      irq_raw = ALL_ACT;
      settle(4);
      for (int l = 0; l < 12; l++) begin
         rd(5'(16 + l), d);
         chk($sformatf("R6 vector line %0d", l), 32'(d), 32'({3'b100, LOWEST[l]}));
      end

      // R4: second-level mask on source 22 blocks line 0 and empties its vector
      wr(5'd6, 8'h40);
      settle(2);
      chk("R4 L2 mask blocks line 0", 32'(irq_out[0]), 32'h0);
      rd(5'd16, d);
      chk("R6 vector empty when none pending", 32'(d), 32'h00);
      // masking source 9 moves line 6's vector to source 10
      wr(5'd5, 8'h02);
      settle(2);
      chk("R4 line 6 stays on via other sources", 32'(irq_out[6]), 32'h1);
      rd(5'd22, d);
      chk("R6 next lowest source", 32'(d), 32'h8A);
      // R4 R9: first-level mask on line 7, output drops on the next edge
      @(negedge clk);
      bus_addr = 5'd8; bus_wdata = 8'h80; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R9 mask write not yet at output", 32'(irq_out[7]), 32'h1);
      @(negedge clk);
      chk("R4 L1 mask blocks line 7", 32'(irq_out[7]), 32'h0);
      rd(5'd23, d);
      chk("R6 vector ignores L1 mask", 32'(d), 32'h80);

      // R8: writes to read-only offsets ignored, unmapped reads zero
      wr(5'd0, 8'h00);
      rd(5'd0, d);
      chk("R8 status write ignored", 32'(d), 32'hFF);
      wr(5'd17, 8'h00);
      rd(5'd17, d);
      chk("R8 vector write ignored", 32'(d), 32'h97);
      wr(5'd10, 8'h33);
      rd(5'd10, d);
      chk("R8 unmapped read 0x0A", 32'(d), 32'h00);
      rd(5'd31, d);
      chk("R8 unmapped read 0x1F", 32'(d), 32'h00);
      settle(2);
      chk("R8 writes left outputs unchanged", 32'(irq_out), 32'hF7E);

      // R9: input latency through the synchroniser
      for (int a = 4; a < 10; a++) wr(5'(a), 8'h00);
      @(negedge clk);
      irq_raw = IDLE_RAW;
      settle(4);
      chk("R9 idle before step", 32'(irq_out), 32'h0);
      irq_raw = IDLE_RAW | 32'h1;
      @(negedge clk);
      @(negedge clk);
      chk("R9 not visible after two edges", 32'(irq_out[7]), 32'h0);
      @(negedge clk);
      chk("R9 visible on third edge", 32'(irq_out[7]), 32'h1);

      finish_run();
   end
endmodule